// File: doc/BRIEF.md
# I/Q Receive Serial Framer

This block takes filtered I/Q sample pairs from a parallel valid interface and sends them out on a single serial data pin. It drives its own bit clock and a frame sync pulse. Each pair goes out as two 16-bit words, I first and then Q. A word holds a 15-bit two's-complement sample, sent most significant bit first, and ends in a channel flag bit.

The bit period is a fixed number of master-clock cycles. In the 4x symbol-rate mode a bit lasts 4 cycles, so a word lasts 64 cycles. In the 2x mode a bit lasts 8 cycles, so a word lasts 128 cycles. The mode is captured when a pair starts to transmit.

One pair can wait in a holding stage while another is being sent. A further pair that arrives while that stage is occupied is dropped, and a sticky overrun flag is raised. A power-down input silences the outputs and clears all state.

Top module: `iq_rx_serializer`

## Requirements
- R1: Each accepted pair is sent as 32 consecutive bits: the I word (bits 14 down to 0 of pair_i), then the Q word (bits 14 down to 0 of pair_q), with no gap between the two words.
- R2: The 16th bit of each word is a channel flag: 0 on the I word and 1 on the Q word.
- R3: A bit period lasts 4 clock cycles when rate_2x is 0 and 8 cycles when it is 1. The value of rate_2x is captured when a pair starts and holds for that whole pair.
- R4: rx_clk is high for the first half of each bit period and low for the second half. rx_data changes only at the start of a bit period. rx_clk, rx_data and rx_sync are all 0 while nothing is being sent.
- R5: rx_sync is 1 during the first bit period of every I word and 0 at all other times.
- R6: A pair that arrives while another pair is being sent is held. It starts in the bit period right after the last bit of the current pair, with no idle gap.
- R7: If pair_valid is sampled while a pair is already held and that pair is not leaving the holding stage in the same cycle, the new pair is dropped and overrun becomes 1. Overrun then stays 1 until power-down or reset.
- R8: While pwr_dn is 1, rx_clk, rx_data and rx_sync are 0 in that same cycle. The transfer in progress and any held pair are discarded, overrun is cleared, and pair_valid is ignored.
- R9: After reset, all four outputs are 0.
- R10: When the block is idle, a pair sampled on clock edge N begins its first bit period (rx_sync high) right after edge N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_dn | input | 1 | Power-down: silences the outputs and clears state |
| rate_2x | input | 1 | 0 selects 4 cycles per bit, 1 selects 8 cycles per bit |
| pair_valid | input | 1 | A new I/Q pair is present this cycle |
| pair_i | input | 15 | I sample |
| pair_q | input | 15 | Q sample |
| rx_clk | output | 1 | Serial bit clock |
| rx_data | output | 1 | Serial data, MSB first |
| rx_sync | output | 1 | Frame sync, high on the first bit of each I word |
| overrun | output | 1 | Sticky flag: a pair was dropped |

## Verification
The assertions check structural behaviour on every cycle. They confirm that the overrun flag falls only after power-down, that the bit phase stays within the selected period, and that the bit index holds between bit boundaries. They also confirm that a held pair is taken the moment the current pair ends. The bench scenarios cover the rest. They show the exact bit sequence and flag values, the first-bit latency, and that the mode is held for a whole pair even when it changes partway through. They also show that a dropped pair never appears on the pin and that pairs offered during power-down are ignored.

// File: rtl/iqs_pkg.sv
package iqs_pkg;
    typedef enum logic {
        RATE_4X = 1'b0,
        RATE_2X = 1'b1
    } rate_e;

    localparam logic FLAG_I = 1'b0;
    localparam logic FLAG_Q = 1'b1;
endpackage

// File: rtl/iqs_bit_timer.sv
module iqs_bit_timer #(
    parameter int FAST_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd,
    input  logic start,
    input  logic rate_sel,
    input  logic run,
    output logic bit_end,
    output logic clk_hi
);
    import iqs_pkg::*;

    localparam int SLOW_DIV = 2 * FAST_DIV;
    localparam int PW = $clog2(SLOW_DIV);
    localparam logic [PW-1:0] LAST_F = PW'(FAST_DIV - 1);
    localparam logic [PW-1:0] LAST_S = PW'(SLOW_DIV - 1);
    localparam logic [PW-1:0] HALF_F = PW'(FAST_DIV / 2);
    localparam logic [PW-1:0] HALF_S = PW'(SLOW_DIV / 2);

    typedef struct packed {
        logic [PW-1:0] phase;
        logic          slow;
    } tmr_t;

    tmr_t s_d, s_q;
    logic [PW-1:0] last_w;
    logic [PW-1:0] half_w;

    always_comb begin
        last_w  = s_q.slow ? LAST_S : LAST_F;
        half_w  = s_q.slow ? HALF_S : HALF_F;
        bit_end = run && (s_q.phase == last_w);
        clk_hi  = run && (s_q.phase < half_w);
        s_d = s_q;
        if (pd) begin
            s_d = '0;
        end else if (start) begin
            s_d.phase = '0;
            s_d.slow  = (rate_e'(rate_sel) == RATE_2X);
        end else if (run) begin
            s_d.phase = bit_end ? '0 : s_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3
    phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.slow |-> (s_q.phase <= LAST_F));
endmodule

// File: rtl/iqs_pair_buffer.sv
module iqs_pair_buffer #(
    parameter int SW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pd,
    input  logic          in_valid,
    input  logic [SW-1:0] in_i,
    input  logic [SW-1:0] in_q,
    input  logic          take,
    output logic          valid,
    output logic [SW-1:0] out_i,
    output logic [SW-1:0] out_q,
    output logic          ovr
);
    typedef struct packed {
        logic          valid;
        logic [SW-1:0] i;
        logic [SW-1:0] q;
        logic          ovr;
    } hold_t;

    hold_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (pd) begin
            s_d.valid = 1'b0;
            s_d.ovr   = 1'b0;
        end else begin
            if (take) s_d.valid = 1'b0;
            if (in_valid) begin
                if (!s_q.valid || take) begin
                    s_d.valid = 1'b1;
                    s_d.i     = in_i;
                    s_d.q     = in_q;
                end else begin
                    s_d.ovr = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign valid = s_q.valid;
    assign out_i = s_q.i;
    assign out_q = s_q.q;
    assign ovr   = s_q.ovr;

    // R6
    take_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> s_q.valid);

    // R7
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.ovr) |-> $past(pd));
endmodule

// File: rtl/iqs_shift_core.sv
module iqs_shift_core #(
    parameter int SW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pd,
    input  logic          start,
    input  logic [SW-1:0] pair_i,
    input  logic [SW-1:0] pair_q,
    input  logic          bit_end,
    output logic          active,
    output logic          done,
    output logic          ser_bit,
    output logic          first_bit
);
    import iqs_pkg::*;

    localparam int WW = SW + 1;
    localparam int FW = 2 * WW;
    localparam int IW = $clog2(FW);
    localparam logic [IW-1:0] LAST_IDX = IW'(FW - 1);

    typedef struct packed {
        logic          active;
        logic [IW-1:0] idx;
        logic [FW-1:0] sh;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        done = s_q.active && bit_end && (s_q.idx == LAST_IDX);
        s_d  = s_q;
        if (pd) begin
            s_d = '0;
        end else if (start) begin
            s_d.active = 1'b1;
            s_d.idx    = '0;
            s_d.sh     = {pair_i, FLAG_I, pair_q, FLAG_Q};
        end else if (done) begin
            s_d.active = 1'b0;
        end else if (s_q.active && bit_end) begin
            s_d.idx = s_q.idx + 1'b1;
            s_d.sh  = {s_q.sh[FW-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active    = s_q.active;
    assign ser_bit   = s_q.sh[FW-1];
    assign first_bit = s_q.active && (s_q.idx == '0);

    // R1
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd && s_q.active && !bit_end && !start) |=> $stable(s_q.idx));
endmodule

// File: rtl/iq_rx_serializer.sv
module iq_rx_serializer #(
    parameter int SAMPLE_W = 15,
    parameter int FAST_DIV = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_dn,
    input  logic                rate_2x,
    input  logic                pair_valid,
    input  logic [SAMPLE_W-1:0] pair_i,
    input  logic [SAMPLE_W-1:0] pair_q,
    output logic                rx_clk,
    output logic                rx_data,
    output logic                rx_sync,
    output logic                overrun
);
    logic                buf_valid;
    logic [SAMPLE_W-1:0] buf_i;
    logic [SAMPLE_W-1:0] buf_q;
    logic                buf_ovr;
    logic                take;
    logic                tx_active;
    logic                tx_done;
    logic                ser_bit;
    logic                first_bit;
    logic                bit_end;
    logic                clk_hi;

    assign take = buf_valid && (!tx_active || tx_done);

    iqs_pair_buffer #(.SW(SAMPLE_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .pd(pwr_dn),
        .in_valid(pair_valid), .in_i(pair_i), .in_q(pair_q),
        .take(take), .valid(buf_valid), .out_i(buf_i), .out_q(buf_q),
        .ovr(buf_ovr)
    );

    iqs_bit_timer #(.FAST_DIV(FAST_DIV)) u_timer (
        .clk(clk), .rst_n(rst_n), .pd(pwr_dn), .start(take),
        .rate_sel(rate_2x), .run(tx_active),
        .bit_end(bit_end), .clk_hi(clk_hi)
    );

    iqs_shift_core #(.SW(SAMPLE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .pd(pwr_dn), .start(take),
        .pair_i(buf_i), .pair_q(buf_q), .bit_end(bit_end),
        .active(tx_active), .done(tx_done), .ser_bit(ser_bit),
        .first_bit(first_bit)
    );

    assign rx_clk  = !pwr_dn && clk_hi;
    assign rx_data = !pwr_dn && tx_active && ser_bit;
    assign rx_sync = !pwr_dn && first_bit;
    assign overrun = buf_ovr;

    // R6
    no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && buf_valid && !pwr_dn) |=> tx_active);
endmodule

// File: tb/test_iq_rx_serializer.sv
module test_iq_rx_serializer;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_dn = 1'b0;
    logic rate_2x = 1'b0;
    logic pair_valid = 1'b0;
    logic [SW-1:0] pair_i = '0;
    logic [SW-1:0] pair_q = '0;
    logic rx_clk, rx_data, rx_sync, overrun;

    int checks = 0;
    int failures = 0;

    iq_rx_serializer #(.SAMPLE_W(SW), .FAST_DIV(4)) i_iq_rx_serializer (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .rate_2x(rate_2x),
        .pair_valid(pair_valid), .pair_i(pair_i), .pair_q(pair_q),
        .rx_clk(rx_clk), .rx_data(rx_data), .rx_sync(rx_sync),
        .overrun(overrun)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // behavioural reference: pending pair list, current pair, cycle count in pair
    logic [SW-1:0] pend_i[$];
    logic [SW-1:0] pend_q[$];
    logic [SW-1:0] cur_i, cur_q;
    int busy = 0, tick = 0, div = 4;
    bit m_ovr = 0;

    function automatic bit word_bit(input logic [SW-1:0] s, input int pos, input bit flag);
        if (pos < SW) return s[SW-1-pos];
        return flag;
    endfunction

    function automatic bit exp_data();
        int b;
        if (pwr_dn || busy == 0) return 1'b0;
        b = tick / div;
        if (b < 16) return word_bit(cur_i, b, 1'b0);
        return word_bit(cur_q, b - 16, 1'b1);
    endfunction

    function automatic bit exp_clk();
        if (pwr_dn || busy == 0) return 1'b0;
        return (tick % div) < (div / 2);
    endfunction

    function automatic bit exp_sync();
        if (pwr_dn || busy == 0) return 1'b0;
        return (tick / div) == 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy = 0; tick = 0; m_ovr = 0;
            pend_i.delete(); pend_q.delete();
        end else if (pwr_dn) begin
            busy = 0; tick = 0; m_ovr = 0;
            pend_i.delete(); pend_q.delete();
        end else begin
            bit had_pend, fin, tk;
            had_pend = (pend_i.size() != 0);
            fin = (busy != 0) && (tick == 32 * div - 1);
            tk = had_pend && (busy == 0 || fin);
            if (busy != 0) begin
                if (fin) busy = 0;
                else tick++;
            end
            if (tk) begin
                busy = 1; tick = 0; div = rate_2x ? 8 : 4;
                cur_i = pend_i.pop_front();
                cur_q = pend_q.pop_front();
            end
            if (pair_valid) begin
                if (!had_pend || tk) begin
                    pend_i.push_back(pair_i);
                    pend_q.push_back(pair_q);
                end else begin
                    m_ovr = 1;
                end
            end
        end
    end

    task automatic check(input string req, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s at %0t: actual=%0b expected=%0b", req, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check("R1 R2 R6 rx_data", rx_data, exp_data());
            check("R3 R4 rx_clk", rx_clk, exp_clk());
            check("R5 rx_sync", rx_sync, exp_sync());
            check("R7 overrun", overrun, m_ovr);
        end
    end

    task automatic send(input logic [SW-1:0] i, input logic [SW-1:0] q);
        @(posedge clk); #1;
        pair_valid = 1'b1; pair_i = i; pair_q = q;
        @(posedge clk); #1;
        pair_valid = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 3 + 1);
        // R9: reset state
        check("R9 rx_clk", rx_clk, 1'b0);
        check("R9 rx_data", rx_data, 1'b0);
        check("R9 rx_sync", rx_sync, 1'b0);
        check("R9 overrun", overrun, 1'b0);
        rst_n = 1'b1;
        wait_cycles(3);

        // R10: latency from idle, 4x mode
        send(15'h5A5A, 15'h2C3D);
        check("R10 sync not yet", rx_sync, 1'b0);
        wait_cycles(1);
        check("R10 sync first bit", rx_sync, 1'b1);
        wait_cycles(140);

        // R3: 2x mode, extreme values
        rate_2x = 1'b1;
        send(15'h7FFF, 15'h0000);
        wait_cycles(270);

        // R3: mode change mid-pair has no effect on that pair
        rate_2x = 1'b0;
        send(15'h1234, 15'h4321);
        wait_cycles(20);
        rate_2x = 1'b1;
        wait_cycles(130);
        rate_2x = 1'b0;

        // R6: pair held and sent back-to-back
        send(15'h0001, 15'h4000);
        wait_cycles(10);
        send(15'h3333, 15'h6666);
        wait_cycles(280);

        // R7: third pair while buffer full is dropped
        send(15'h0F0F, 15'h70F0);
        send(15'h1111, 15'h2222);
        send(15'h5555, 15'h2AAA);
        check("R7 overrun set", overrun, 1'b1);
        wait_cycles(300);
        check("R7 overrun sticky", overrun, 1'b1);

        // R8: power-down mid transfer
        send(15'h6DB6, 15'h1249);
        wait_cycles(30);
        pwr_dn = 1'b1;
        #1;
        check("R8 rx_clk low", rx_clk, 1'b0);
        check("R8 rx_data low", rx_data, 1'b0);
        check("R8 rx_sync low", rx_sync, 1'b0);
        send(15'h7777, 15'h7777);
        wait_cycles(2);
        check("R8 overrun cleared", overrun, 1'b0);
        pwr_dn = 1'b0;
        for (int k = 0; k < 40; k++) begin
            check("R8 ignored pair absent", rx_sync, 1'b0);
            wait_cycles(1);
        end

        // normal operation resumes
        send(15'h2AAA, 15'h5555);
        wait_cycles(140);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule